// File: doc/BRIEF.md
# Multi-function configurable logic cell

This block is a bank of configurable logic cells. Each cell receives four sum-of-products inputs from a logic array, called A, B, C and D. Each cell owns one storage element and drives three outputs. A static 18-bit configuration word per cell decides several things: which sum inputs act as data, K, preset, reset, clock or output enable; the register type (D, T or JK); the clock source and its polarity; whether the group-wide preset and reset reach the cell; and what the two general outputs select. A group-wide run-time type control can move chosen cells from D behaviour to T or JK behaviour. One use is a counter that loads in D mode and counts in T mode.

The block runs entirely from one fast system clock `clk`. Every clock source is an ordinary signal: the shared clock line `gclk_i`, sum C or sum D. The cell samples the selected source on each `clk` rising edge and detects a change of level. An active edge of the selected source updates the register on the `clk` edge at which the source is first seen at its new level. So after the source's active transition, the register output changes one `clk` edge later. Preset and reset act at once on the cell's Q output. They also force the stored value on the next `clk` edge, so the forced value remains after they are released.

Top module: `mfx_logic_cell`

## Requirements
- R1: While `rst_n` is low, and after it is released, every stored Q is 0. A cell whose D-use field (bits 17:16) is 0 drives `oe_o` 1 and `fb_o` 0.
- R2: With type field bits 7:6 = 0 (D), an active clock edge stores sum A. Code 3 in this field also behaves as D.
- R3: With no active clock edge, and with no preset or reset asserted, Q holds its value whatever the sum inputs do.
- R4: Clock source field bits 4:3 = 0 selects `gclk_i`. Bit 5 = 0 makes the rising transition active, and bit 5 = 1 makes the falling transition active. The other transition changes nothing.
- R5: With type code 1 (T), an active edge inverts Q when sum A is 1 and holds Q when sum A is 0.
- R6: With type code 2 (JK), sum A is J. K is sum B when bit 1 is set and is 0 otherwise. J/K = 1/1 inverts Q, 0/0 holds, 1/0 sets Q to 1 and 0/1 clears Q to 0.
- R7: When bit 8 is set and `gtype_i` is 1, the cell acts as T (bit 9 = 0) or as JK (bit 9 = 1), whatever its type field says. Otherwise the type field applies.
- R8: Clock source code 1 clocks the register from sum C and code 2 clocks it from sum D. `gclk_i` then has no effect on Q.
- R9: Bit 0 makes sum B a preset and bit 2 makes sum C a reset. Each acts on Q at once and leaves that value stored after release. When preset and reset are asserted together, Q is 0.
- R10: `gset_i` presets the cell only when bit 10 is set, and `gclr_i` resets it only when bit 11 is set. Reset takes priority here as well.
- R11: `y0_o` (select bits 13:12) and `y1_o` (select bits 15:14) each show Q (0), sum A (1), sum B (2) or sum C (3), independently of each other.
- R12: D-use code 1 drives `oe_o` from sum D, with `fb_o` 0. Code 2 drives `fb_o` from sum D, with `oe_o` 1.
- R13: Cell n uses config bits [18n+17:18n] and bit n of every per-cell bus. Activity in one cell does not change another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of all state |
| cfg_i | input | 18*N_CELLS | Static configuration words, one per cell |
| gclk_i | input | 1 | Shared clock line, sampled as a clock source |
| gset_i | input | 1 | Group preset |
| gclr_i | input | 1 | Group reset |
| gtype_i | input | 1 | Run-time register type switch |
| sum_a_i | input | N_CELLS | Sum A per cell |
| sum_b_i | input | N_CELLS | Sum B per cell |
| sum_c_i | input | N_CELLS | Sum C per cell |
| sum_d_i | input | N_CELLS | Sum D per cell |
| y0_o | output | N_CELLS | First selectable output per cell |
| y1_o | output | N_CELLS | Second selectable output per cell |
| oe_o | output | N_CELLS | Output enable per cell |
| fb_o | output | N_CELLS | Buried feedback of sum D per cell |

## Verification
The bench checks the transition the polarity bit rejects. A design with the polarity inverted would load on the wrong half of a `gclk_i` pulse, and one that treats both transitions as active would load twice. It drives preset and reset together and expects 0. A design with the priority reversed would leave Q at 1. It runs the run-time type switch with data chosen so that D and T give different answers. A design that ignores `gtype_i` would reload instead of toggling. It also confirms that `gclk_i` pulses do nothing once a sum term is the clock, and that a K input not routed from sum B reads as 0.

// File: rtl/mfx_cell_pkg.sv
package mfx_cell_pkg;

   localparam int CFG_W = 18;

   typedef enum logic [1:0] {
      RT_D   = 2'd0,
      RT_T   = 2'd1,
      RT_JK  = 2'd2,
      RT_RSV = 2'd3
   } rtype_e;

   typedef enum logic [1:0] {
      CK_GLOBAL = 2'd0,
      CK_SUMC   = 2'd1,
      CK_SUMD   = 2'd2,
      CK_RSV    = 2'd3
   } ck_src_e;

   typedef enum logic [1:0] {
      OS_Q = 2'd0,
      OS_A = 2'd1,
      OS_B = 2'd2,
      OS_C = 2'd3
   } osel_e;

   typedef enum logic [1:0] {
      DU_NONE = 2'd0,
      DU_OE   = 2'd1,
      DU_FB   = 2'd2,
      DU_RSV  = 2'd3
   } duse_e;

   // packed MSB first: d_use[17:16] ... b_is_pre[0]
   typedef struct packed {
      duse_e   d_use;
      osel_e   sel1;
      osel_e   sel0;
      logic    use_grst;
      logic    use_gpre;
      logic    alt_jk;
      logic    dyn_en;
      rtype_e  rtype;
      logic    clk_fall;
      ck_src_e clk_src;
      logic    c_is_rst;
      logic    b_is_k;
      logic    b_is_pre;
   } cell_cfg_t;

   function automatic rtype_e eff_type(input cell_cfg_t c, input logic grt);
      rtype_e t;
      if (c.dyn_en && grt)
         t = c.alt_jk ? RT_JK : RT_T;
      else if (c.rtype == RT_RSV)
         t = RT_D;
      else
         t = c.rtype;
      return t;
   endfunction

endpackage

// File: rtl/mfx_edge_det.sv
module mfx_edge_det #(
   parameter bit PREV_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   input  logic fall,
   output logic fire
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= PREV_INIT;
      else
         prev_q <= src;
   end

   assign fire = fall ? (prev_q & ~src) : (~prev_q & src);

   // R4: one transition gives one active edge, never two in a row
   a_r4_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (!fire || (fall != $past(fall))));

endmodule

// File: rtl/mfx_reg_core.sv
module mfx_reg_core
   import mfx_cell_pkg::*;
#(
   parameter bit HAS_JK = 1'b1,
   parameter bit Q_INIT = 1'b0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   fire,
   input  rtype_e typ,
   input  logic   din,
   input  logic   kin,
   input  logic   set_i,
   input  logic   clr_i,
   output logic   q_o
);

   rtype_e typ_eff;
   logic   q_reg;
   logic   q_next;

   generate
      if (HAS_JK) begin : g_jk
         assign typ_eff = typ;
      end else begin : g_nojk
         assign typ_eff = (typ == RT_JK) ? RT_D : typ;
      end
   endgenerate

   always_comb begin
      case (typ_eff)
         RT_T:    q_next = q_reg ^ din;
         RT_JK:   q_next = (din & ~q_reg) | (~kin & q_reg);
         default: q_next = din;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_reg <= Q_INIT;
      else if (clr_i)
         q_reg <= 1'b0;
      else if (set_i)
         q_reg <= 1'b1;
      else if (fire)
         q_reg <= q_next;
   end

   // level override, reset above preset
   assign q_o = clr_i ? 1'b0 : (set_i ? 1'b1 : q_reg);

   // R3: nothing moves the register without an edge or an override
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && !set_i && !clr_i) |=> (q_reg == $past(q_reg)));

   // R5: T with data 1 inverts
   a_r5_t_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && typ_eff == RT_T && din && !set_i && !clr_i) |=> (q_reg != $past(q_reg)));

   // R6: JK set and clear
   a_r6_jk_set: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && typ_eff == RT_JK && din && !kin && !set_i && !clr_i) |=> q_reg);

   a_r6_jk_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && typ_eff == RT_JK && !din && kin && !set_i && !clr_i) |=> !q_reg);

   // R9: reset beats preset and sticks
   a_r9_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !q_reg);

endmodule

// File: rtl/mfx_out_sel.sv
module mfx_out_sel
   import mfx_cell_pkg::*;
(
   input  osel_e sel,
   input  logic  q,
   input  logic  a,
   input  logic  b,
   input  logic  c,
   output logic  y
);

   always_comb begin
      case (sel)
         OS_A:    y = a;
         OS_B:    y = b;
         OS_C:    y = c;
         default: y = q;
      endcase
   end

endmodule

// File: rtl/mfx_cell.sv
module mfx_cell
   import mfx_cell_pkg::*;
#(
   parameter bit HAS_JK = 1'b1,
   parameter bit Q_INIT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_i,
   input  logic             gclk,
   input  logic             gset,
   input  logic             gclr,
   input  logic             gtype,
   input  logic             sum_a,
   input  logic             sum_b,
   input  logic             sum_c,
   input  logic             sum_d,
   output logic             y0,
   output logic             y1,
   output logic             oe,
   output logic             fb
);

   cell_cfg_t cfg;
   logic      ck_src;
   logic      fire;
   logic      set_act;
   logic      clr_act;
   logic      k_in;
   logic      q;
   rtype_e    typ;
   osel_e     sel [2];
   logic      ysel [2];

   assign cfg = cell_cfg_t'(cfg_i);

   always_comb begin
      case (cfg.clk_src)
         CK_SUMC: ck_src = sum_c;
         CK_SUMD: ck_src = sum_d;
         default: ck_src = gclk;
      endcase
   end

   mfx_edge_det #(.PREV_INIT(1'b0)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (ck_src),
      .fall  (cfg.clk_fall),
      .fire  (fire)
   );

   assign set_act = (cfg.b_is_pre & sum_b) | (cfg.use_gpre & gset);
   assign clr_act = (cfg.c_is_rst & sum_c) | (cfg.use_grst & gclr);
   assign k_in    = cfg.b_is_k & sum_b;
   assign typ     = eff_type(cfg, gtype);

   mfx_reg_core #(.HAS_JK(HAS_JK), .Q_INIT(Q_INIT)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .typ   (typ),
      .din   (sum_a),
      .kin   (k_in),
      .set_i (set_act),
      .clr_i (clr_act),
      .q_o   (q)
   );

   assign sel[0] = cfg.sel0;
   assign sel[1] = cfg.sel1;

   generate
      for (genvar o = 0; o < 2; o++) begin : g_out
         mfx_out_sel u_sel (
            .sel (sel[o]),
            .q   (q),
            .a   (sum_a),
            .b   (sum_b),
            .c   (sum_c),
            .y   (ysel[o])
         );
      end
   endgenerate

   assign y0 = ysel[0];
   assign y1 = ysel[1];
   assign oe = (cfg.d_use == DU_OE) ? sum_d : 1'b1;
   assign fb = (cfg.d_use == DU_FB) ? sum_d : 1'b0;

   // R12: feedback only appears while the pin is enabled as a dedicated output
   a_r12_fb_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
      fb |-> oe);

endmodule

// File: rtl/mfx_logic_cell.sv
module mfx_logic_cell
   import mfx_cell_pkg::*;
#(
   parameter int N_CELLS = 2,
   parameter bit HAS_JK  = 1'b1,
   parameter bit Q_INIT  = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_CELLS*CFG_W-1:0]   cfg_i,
   input  logic                       gclk_i,
   input  logic                       gset_i,
   input  logic                       gclr_i,
   input  logic                       gtype_i,
   input  logic [N_CELLS-1:0]         sum_a_i,
   input  logic [N_CELLS-1:0]         sum_b_i,
   input  logic [N_CELLS-1:0]         sum_c_i,
   input  logic [N_CELLS-1:0]         sum_d_i,
   output logic [N_CELLS-1:0]         y0_o,
   output logic [N_CELLS-1:0]         y1_o,
   output logic [N_CELLS-1:0]         oe_o,
   output logic [N_CELLS-1:0]         fb_o
);

   localparam int MAX_CELLS = 64;

   generate
      if (N_CELLS < 1 || N_CELLS > MAX_CELLS) begin : g_bad_count
         $error("mfx_logic_cell: N_CELLS out of range");
      end
   endgenerate

   generate
      for (genvar n = 0; n < N_CELLS; n++) begin : g_cell
         localparam int LO = n * CFG_W;
         mfx_cell #(.HAS_JK(HAS_JK), .Q_INIT(Q_INIT)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg_i (cfg_i[LO +: CFG_W]),
            .gclk  (gclk_i),
            .gset  (gset_i),
            .gclr  (gclr_i),
            .gtype (gtype_i),
            .sum_a (sum_a_i[n]),
            .sum_b (sum_b_i[n]),
            .sum_c (sum_c_i[n]),
            .sum_d (sum_d_i[n]),
            .y0    (y0_o[n]),
            .y1    (y1_o[n]),
            .oe    (oe_o[n]),
            .fb    (fb_o[n])
         );
      end
   endgenerate

endmodule

// File: tb/mfx_logic_cell_tb.sv
module mfx_logic_cell_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [35:0] cfg;
   logic        gclk, gset, gclr, gtype;
   logic [1:0]  sa, sb, sc, sd;
   logic [1:0]  y0, y1, oe, fb;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   mfx_logic_cell #(.N_CELLS(2)) u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_i   (cfg),
      .gclk_i  (gclk),
      .gset_i  (gset),
      .gclr_i  (gclr),
      .gtype_i (gtype),
      .sum_a_i (sa),
      .sum_b_i (sb),
      .sum_c_i (sc),
      .sum_d_i (sd),
      .y0_o    (y0),
      .y1_o    (y1),
      .oe_o    (oe),
      .fb_o    (fb)
   );

   // field layout taken from the requirements
   function automatic logic [17:0] mk(input logic [1:0] rt, input logic [1:0] src,
                                      input logic fall, input logic bk, input logic bpre,
                                      input logic crst, input logic dyn, input logic alt,
                                      input logic gp, input logic gr, input logic [1:0] s0,
                                      input logic [1:0] s1, input logic [1:0] du);
      logic [17:0] w;
      w = '0;
      w[0] = bpre; w[1] = bk; w[2] = crst; w[4:3] = src; w[5] = fall;
      w[7:6] = rt; w[8] = dyn; w[9] = alt; w[10] = gp; w[11] = gr;
      w[13:12] = s0; w[15:14] = s1; w[17:16] = du;
      return w;
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_g();
      gclk = 1'b1; tick(); gclk = 1'b0; tick();
   endtask

   task automatic pulse_c();
      sc[0] = 1'b1; tick(); sc[0] = 1'b0; tick();
   endtask

   task automatic pulse_d();
      sd[0] = 1'b1; tick(); sd[0] = 1'b0; tick();
   endtask

   task automatic t_reset();
      cfg[17:0]  = mk(2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      cfg[35:18] = mk(2'd1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      rst_n = 1'b0;
      repeat (3) tick();
      chk("R1 q in reset", y0[0], 1'b0);
      rst_n = 1'b1;
      tick();
      chk("R1 q after reset", y0[0], 1'b0);
      chk("R1 q cell1 after reset", y0[1], 1'b0);
      chk("R1 oe default", oe[0], 1'b1);
      chk("R1 fb default", fb[0], 1'b0);
   endtask

   task automatic t_dtype();
      sa[0] = 1'b1; tick(); tick();
      chk("R3 no edge hold", y0[0], 1'b0);
      pulse_g();
      chk("R2 D load 1", y0[0], 1'b1);
      sa[0] = 1'b0; tick();
      chk("R3 data change no edge", y0[0], 1'b1);
      pulse_g();
      chk("R2 D load 0", y0[0], 1'b0);
      cfg[17:0] = mk(2'd3, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      sa[0] = 1'b1; pulse_g();
      chk("R2 code3 acts as D", y0[0], 1'b1);
      sa[0] = 1'b0; pulse_g();
      chk("R2 code3 load 0", y0[0], 1'b0);
   endtask

   task automatic t_polarity();
      cfg[17:0] = mk(2'd0, 2'd0, 1, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      sa[0] = 1'b1;
      gclk = 1'b1; tick();
      chk("R4 rising ignored when falling set", y0[0], 1'b0);
      gclk = 1'b0; tick();
      chk("R4 falling edge loads", y0[0], 1'b1);
   endtask

   task automatic t_ttype();
      cfg[17:0] = mk(2'd1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      sa[0] = 1'b1; pulse_g();
      chk("R5 T toggle to 0", y0[0], 1'b0);
      pulse_g();
      chk("R5 T toggle to 1", y0[0], 1'b1);
      sa[0] = 1'b0; pulse_g();
      chk("R5 T hold", y0[0], 1'b1);
   endtask

   task automatic t_jk();
      cfg[17:0] = mk(2'd2, 2'd0, 0, 1, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      sa[0] = 1'b0; sb[0] = 1'b1; pulse_g();
      chk("R6 JK 0/1 clears", y0[0], 1'b0);
      sa[0] = 1'b1; sb[0] = 1'b0; pulse_g();
      chk("R6 JK 1/0 sets", y0[0], 1'b1);
      sa[0] = 1'b0; sb[0] = 1'b0; pulse_g();
      chk("R6 JK 0/0 holds", y0[0], 1'b1);
      sa[0] = 1'b1; sb[0] = 1'b1; pulse_g();
      chk("R6 JK 1/1 toggles", y0[0], 1'b0);
      pulse_g();
      chk("R6 JK 1/1 toggles back", y0[0], 1'b1);
      cfg[17:0] = mk(2'd2, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      sa[0] = 1'b0; sb[0] = 1'b1; pulse_g();
      chk("R6 unrouted K reads 0", y0[0], 1'b1);
      sb[0] = 1'b0;
   endtask

   task automatic t_dynamic();
      cfg[17:0] = mk(2'd0, 2'd0, 0, 0, 0, 0, 1, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      gtype = 1'b0; sa[0] = 1'b0; pulse_g();
      chk("R7 D phase loads", y0[0], 1'b0);
      gtype = 1'b1; sa[0] = 1'b1; pulse_g();
      chk("R7 T phase toggle", y0[0], 1'b1);
      pulse_g();
      chk("R7 T phase toggle again", y0[0], 1'b0);
      gtype = 1'b0; pulse_g();
      chk("R7 back to D", y0[0], 1'b1);
      cfg[17:0] = mk(2'd0, 2'd0, 0, 1, 0, 0, 1, 1, 0, 0, 2'd0, 2'd0, 2'd0);
      gtype = 1'b1; sa[0] = 1'b0; sb[0] = 1'b1; pulse_g();
      chk("R7 JK phase clear", y0[0], 1'b0);
      sa[0] = 1'b1; pulse_g();
      chk("R7 JK phase toggle", y0[0], 1'b1);
      pulse_g();
      chk("R7 JK phase toggle again", y0[0], 1'b0);
      cfg[17:0] = mk(2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      sb[0] = 1'b0; pulse_g(); pulse_g();
      chk("R7 switch ignored without enable", y0[0], 1'b1);
      gtype = 1'b0; sa[0] = 1'b0;
   endtask

   task automatic t_clksrc();
      cfg[17:0] = mk(2'd0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      pulse_g();
      chk("R8 global clock ignored", y0[0], 1'b1);
      pulse_c();
      chk("R8 sum C clocks", y0[0], 1'b0);
      cfg[17:0] = mk(2'd0, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      sa[0] = 1'b1; pulse_d();
      chk("R8 sum D clocks", y0[0], 1'b1);
      sa[0] = 1'b0; pulse_c();
      chk("R8 sum C ignored when D clocks", y0[0], 1'b1);
   endtask

   task automatic t_prerst();
      cfg[17:0] = mk(2'd0, 2'd0, 0, 0, 1, 1, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      sa[0] = 1'b0; pulse_g();
      chk("R9 start at 0", y0[0], 1'b0);
      sb[0] = 1'b1; #1;
      chk("R9 preset immediate", y0[0], 1'b1);
      tick(); sb[0] = 1'b0; #1;
      chk("R9 preset stored", y0[0], 1'b1);
      sc[0] = 1'b1; #1;
      chk("R9 reset immediate", y0[0], 1'b0);
      sb[0] = 1'b1; #1;
      chk("R9 reset wins", y0[0], 1'b0);
      tick(); sb[0] = 1'b0; sc[0] = 1'b0; tick();
      chk("R9 reset stored", y0[0], 1'b0);
      gset = 1'b1; tick();
      chk("R10 group preset gated off", y0[0], 1'b0);
      cfg[17:0] = mk(2'd0, 2'd0, 0, 0, 1, 1, 0, 0, 1, 0, 2'd0, 2'd0, 2'd0); #1;
      chk("R10 group preset enabled", y0[0], 1'b1);
      tick(); gset = 1'b0; gclr = 1'b1; tick();
      chk("R10 group reset gated off", y0[0], 1'b1);
      cfg[17:0] = mk(2'd0, 2'd0, 0, 0, 1, 1, 0, 0, 1, 1, 2'd0, 2'd0, 2'd0); #1;
      chk("R10 group reset enabled", y0[0], 1'b0);
      gset = 1'b1; #1;
      chk("R10 group reset wins", y0[0], 1'b0);
      tick(); gset = 1'b0; gclr = 1'b0; tick();
      chk("R10 reset stored", y0[0], 1'b0);
   endtask

   task automatic t_outsel();
      cfg[17:0] = mk(2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd1, 2'd2, 2'd0);
      sa[0] = 1'b1; sb[0] = 1'b0; #1;
      chk("R11 y0 shows A", y0[0], 1'b1);
      chk("R11 y1 shows B", y1[0], 1'b0);
      sa[0] = 1'b0; sb[0] = 1'b1; #1;
      chk("R11 y0 follows A", y0[0], 1'b0);
      chk("R11 y1 follows B", y1[0], 1'b1);
      cfg[17:0] = mk(2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd3, 2'd0, 2'd0);
      sb[0] = 1'b0; sc[0] = 1'b1; #1;
      chk("R11 y0 shows C", y0[0], 1'b1);
      chk("R11 y1 shows Q", y1[0], 1'b0);
      sa[0] = 1'b1; pulse_g();
      chk("R11 y1 Q after load", y1[0], 1'b1);
      sc[0] = 1'b0; #1;
      chk("R11 y0 follows C", y0[0], 1'b0);
      sa[0] = 1'b0;
   endtask

   task automatic t_duse();
      cfg[17:0] = mk(2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd1);
      sd[0] = 1'b0; #1;
      chk("R12 oe from D low", oe[0], 1'b0);
      chk("R12 fb off in oe mode", fb[0], 1'b0);
      sd[0] = 1'b1; #1;
      chk("R12 oe from D high", oe[0], 1'b1);
      cfg[17:0] = mk(2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd2); #1;
      chk("R12 fb from D high", fb[0], 1'b1);
      chk("R12 oe forced in fb mode", oe[0], 1'b1);
      sd[0] = 1'b0; #1;
      chk("R12 fb from D low", fb[0], 1'b0);
      chk("R12 oe stays on", oe[0], 1'b1);
   endtask

   task automatic t_indep();
      cfg[17:0] = mk(2'd1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0);
      sa[0] = 1'b0;
      chk("R13 cell1 untouched by cell0 tests", y0[1], 1'b0);
      chk("R13 cell1 oe default", oe[1], 1'b1);
      sa[1] = 1'b1; pulse_g();
      chk("R13 cell1 toggles", y0[1], 1'b1);
      chk("R13 cell0 holds", y0[0], 1'b1);
      pulse_g();
      chk("R13 cell1 toggles back", y0[1], 1'b0);
      sa[1] = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; cfg = '0;
      gclk = 1'b0; gset = 1'b0; gclr = 1'b0; gtype = 1'b0;
      sa = '0; sb = '0; sc = '0; sd = '0;
      tick();
      t_reset();
      t_dtype();
      t_polarity();
      t_ttype();
      t_jk();
      t_dynamic();
      t_clksrc();
      t_prerst();
      t_outsel();
      t_duse();
      t_indep();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule